// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes on a synchronous serial link with its own clock line. A host writes a byte into a holding register. When transmission is enabled and the holding register carries a new byte, the block copies that byte into a shift register and sends it on the data pin one bit per serial clock, bit 0 first. The holding register is then free again, so the host can queue the following byte while the current one is still on the wire.

The serial clock either comes from an internal divider of the system clock, and is driven out on the clock pin, or is taken from an external clock input that is first brought into the system-clock domain. Two status flags tell the host where the transmitter stands: one shows that the holding register may be written, and one shows that the line has gone quiet. Each flag has an enable and a level interrupt request. If a new byte is waiting when the last bit of a frame goes out, the next frame follows with no gap. If no byte is waiting, the data pin keeps the last bit's value and the clock pin rests high.

Top module: `sync_tx_top`

## Requirements
- R1: After reset the holding-empty flag is 1, the transmit-end flag is 1, the clock pin is high and the data pin is 1.
- R2: A host write stores the byte, and from the next cycle both the holding-empty flag and the transmit-end flag read 0.
- R3: While enabled, idle and the holding-empty flag is 0, the block loads the holding register into the shift register and sets the holding-empty flag back to 1 in the same edge. The empty request output equals the holding-empty flag ANDed with its enable.
- R4: In clock output mode the clock pin is high when idle. It toggles every div+1 system clocks while a frame runs, and gives exactly eight low pulses per byte.
- R5: Bits leave the data pin from bit 0 to bit 7. In clock output mode the data pin changes at the same system edge that drives the clock pin low, and it is stable at each rising clock edge.
- R6: If the holding-empty flag is 0 at the falling serial edge that emits bit 7, the next byte is loaded at that edge. Its bit 0 follows one serial period later, with the clock running on without a pause.
- R7: If the holding-empty flag is 1 at that edge, the transmit-end flag is set at that edge. The data pin keeps bit 7's value. The frame closes at the following rising serial edge, and the clock pin then stays high.
- R8: The end request output equals the transmit-end flag ANDed with its enable.
- R9: With the external clock selected, the input passes a two-stage synchroniser. A falling input edge moves the data pin at the third rising system edge after the change. The clock pin stays high.
- R10: While the enable is 0 nothing is loaded, no clock pulses appear and the clock pin is high. Dropping the enable mid-frame returns the block to idle, and writes are still accepted.
- R11: A write in the same cycle as a load leaves the older byte in the shift register and keeps the new one pending, with the holding-empty flag at 0. A write in the same cycle as the last-bit decision wins over setting the transmit-end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 holds the transmitter idle |
| clk_out_mode | input | 1 | 1: internal divided clock driven on sclk_o; 0: external clock on sclk_i |
| div_sel | input | DIV_W | Half-period of the internal serial clock, minus one, in system clocks |
| sclk_i | input | 1 | External serial clock |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte written by the host |
| ie_empty | input | 1 | Enable for the empty request |
| ie_end | input | 1 | Enable for the end request |
| flag_empty | output | 1 | Holding register may be written |
| flag_end | output | 1 | Transmission has ended |
| irq_empty | output | 1 | Empty interrupt request (level) |
| irq_end | output | 1 | End interrupt request (level) |
| sclk_o | output | 1 | Serial clock pin, high at rest |
| txd_o | output | 1 | Serial data pin |

## Verification
Two functions can fall in the same system cycle: a host write, and the transmitter's decision at the bit-7 falling edge whether to chain a new byte or finish. Another pair is a host write and an idle load. The bench provokes both by writing a first byte, waiting for it to be loaded, and then issuing the second write after a delay that is swept one cycle at a time across the whole frame, with the fastest divider. Every cycle is compared with a behavioural model that applies the write after the load or end decision. Each round also checks, from the bits a receiver captures on the rising serial edges, that both bytes arrive complete and in order.

// File: rtl/sync_tx_pkg.sv
// Package: shared types of the synchronous serial transmitter.
// Assumes nothing beyond IEEE 1800-2017.
package sync_tx_pkg;

    // Shifter phases: idle, shifting bits, waiting for the final rising edge.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DRAIN = 2'd2
    } sh_state_e;

endpackage

// File: rtl/sync_tx_clkgen.sv
// Module: internal serial clock generator.
// While run_i is 1 it toggles sclk_o every div_i+1 system clocks, starting
// from high, and flags the system cycle whose edge makes each transition.
// While run_i is 0 the clock rests high and the divider counter is cleared.
// Assumes div_i is held stable while run_i is 1.
module sync_tx_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output logic             fall_tk_o,
    output logic             rise_tk_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             hit;

    // Divider terminal count reached while running.
    assign hit       = run_i && (cnt_q == div_i);
    assign fall_tk_o = hit && sclk_q;
    assign rise_tk_o = hit && !sclk_q;
    assign sclk_o    = sclk_q;

    // Divider counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (hit) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sync_tx_edge.sv
// Module: external serial clock synchroniser and edge detector.
// Brings ext_i through STAGES flops and flags falling and rising edges of
// the synchronised level while run_i is 1. The chain runs at all times, so
// an edge is seen with the same latency whenever detection starts.
// Assumes ext_i is slow against clk (each level lasts several clk cycles).
module sync_tx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ext_i,
    output logic fall_tk_o,
    output logic rise_tk_o
);

    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              prev_q;
    logic              lvl;

    // Next value of the synchroniser chain; the shape depends on its depth.
    generate
        if (STAGES == 1) begin : g_one
            assign sync_d = ext_i;
        end else begin : g_many
            assign sync_d = {sync_q[STAGES-2:0], ext_i};
        end
    endgenerate

    assign lvl       = sync_q[STAGES-1];
    assign fall_tk_o = run_i && prev_q && !lvl;
    assign rise_tk_o = run_i && !prev_q && lvl;

    // Synchroniser chain and last-seen level, resting high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= lvl;
        end
    end

endmodule

// File: rtl/sync_tx_shifter.sv
// Module: holding register, shift register, flags and frame sequencing.
// Consumes one-cycle falling and rising serial-edge pulses. A falling pulse
// puts the next bit on the data pin. After the last bit it either chains
// the pending byte or enters a drain phase that closes on the next rising
// pulse. A host write has priority over flag updates made in the same cycle.
// Assumes DATA_W >= 2.
module sync_tx_shifter
    import sync_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              fall_tk_i,
    input  logic              rise_tk_i,
    output logic              flag_empty_o,
    output logic              flag_end_o,
    output logic              txd_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sh_state_e         state_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              empty_q;
    logic              end_q;
    logic              txd_q;

    logic load_idle;
    logic last_fall;
    logic chain;
    logic finish;

    // Frame decisions taken in this cycle.
    assign load_idle = tx_en_i && (state_q == ST_IDLE) && !empty_q;
    assign last_fall = tx_en_i && (state_q == ST_SHIFT) && fall_tk_i
                       && (cnt_q == LAST_BIT);
    assign chain     = last_fall && !empty_q;
    assign finish    = last_fall && empty_q;

    assign flag_empty_o = empty_q;
    assign flag_end_o   = end_q;
    assign txd_o        = txd_q;
    assign busy_o       = (state_q != ST_IDLE);

    // Holding register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en_i) begin
            hold_q <= wr_data_i;
        end
    end

    // Holding-empty flag: a write clears it, a load sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (wr_en_i) begin
            empty_q <= 1'b0;
        end else if (load_idle || chain) begin
            empty_q <= 1'b1;
        end
    end

    // Transmit-end flag: a write clears it, an unchained last bit sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b1;
        end else if (wr_en_i) begin
            end_q <= 1'b0;
        end else if (finish) begin
            end_q <= 1'b1;
        end
    end

    // Frame sequencing, shift register and data pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            txd_q   <= 1'b1;
        end else if (!tx_en_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load_idle) begin
                        sh_q    <= hold_q;
                        cnt_q   <= '0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (fall_tk_i) begin
                        txd_q <= sh_q[0];
                        if (cnt_q == LAST_BIT) begin
                            cnt_q <= '0;
                            if (chain) begin
                                sh_q <= hold_q;
                            end else begin
                                state_q <= ST_DRAIN;
                            end
                        end else begin
                            sh_q  <= sh_q >> 1;
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (rise_tk_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sync_tx_top.sv
// Module: top of the clocked synchronous serial transmitter.
// Picks the serial edge source (internal divider or synchronised external
// clock), feeds the edges to the shifter and forms the level interrupt
// requests. Assumes clk_out_mode and div_sel are changed only while idle.
module sync_tx_top #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              clk_out_mode,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              sclk_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ie_empty,
    input  logic              ie_end,
    output logic              flag_empty,
    output logic              flag_end,
    output logic              irq_empty,
    output logic              irq_end,
    output logic              sclk_o,
    output logic              txd_o
);

    logic busy;
    logic run_int;
    logic run_ext;
    logic int_fall;
    logic int_rise;
    logic ext_fall;
    logic ext_rise;
    logic fall_tk;
    logic rise_tk;

    // Edge sources run only while a frame is in progress.
    assign run_int = tx_en && busy && clk_out_mode;
    assign run_ext = tx_en && busy && !clk_out_mode;

    sync_tx_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_int),
        .div_i     (div_sel),
        .sclk_o    (sclk_o),
        .fall_tk_o (int_fall),
        .rise_tk_o (int_rise)
    );

    sync_tx_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_ext),
        .ext_i     (sclk_i),
        .fall_tk_o (ext_fall),
        .rise_tk_o (ext_rise)
    );

    // Serial edge selection by clock mode.
    assign fall_tk = clk_out_mode ? int_fall : ext_fall;
    assign rise_tk = clk_out_mode ? int_rise : ext_rise;

    sync_tx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en_i      (tx_en),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .fall_tk_i    (fall_tk),
        .rise_tk_i    (rise_tk),
        .flag_empty_o (flag_empty),
        .flag_end_o   (flag_end),
        .txd_o        (txd_o),
        .busy_o       (busy)
    );

    // Level interrupt requests.
    assign irq_empty = flag_empty && ie_empty;
    assign irq_end   = flag_end && ie_end;

endmodule

// File: rtl/sync_tx_checker.sv
// Module: protocol assertions for sync_tx_top, attached by bind.
// Observes ports and the shared edge and busy signals of the top.
module sync_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_en,
    input logic fall_tk,
    input logic busy,
    input logic sclk_o,
    input logic txd_o,
    input logic flag_empty,
    input logic flag_end
);

    // R2: a write clears both flags on the next cycle.
    assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!flag_empty && !flag_end));

    // R4: the clock pin rests high whenever no frame is running.
    assert_idle_clk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o);

    // R5: the data pin moves only at a falling serial edge.
    assert_txd_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tk |=> $stable(txd_o));

    // R7: the transmit-end flag rises only at a falling serial edge.
    assert_end_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_end) |-> $past(fall_tk));

    // R10: with the enable low the block is idle and the clock high.
    assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (sclk_o && !busy));

endmodule

bind sync_tx_top sync_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .wr_en      (wr_en),
    .fall_tk    (fall_tk),
    .busy       (busy),
    .sclk_o     (sclk_o),
    .txd_o      (txd_o),
    .flag_empty (flag_empty),
    .flag_end   (flag_end)
);

// File: tb/sim_sync_tx_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model of the transmitter compared on every
// clock, plus receiver-side checks of the bits on the line.
module sim_sync_tx_top;

    localparam int DW   = 8;
    localparam int DIVW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tx_en = 1'b0;
    logic            clk_out_mode = 1'b1;
    logic [DIVW-1:0] div_sel = '0;
    logic            sclk_i = 1'b1;
    logic            wr_en = 1'b0;
    logic [DW-1:0]   wr_data = '0;
    logic            ie_empty = 1'b0;
    logic            ie_end = 1'b0;
    logic            flag_empty, flag_end, irq_empty, irq_end, sclk_o, txd_o;

    always #2 clk = ~clk;

    sync_tx_top #(.DATA_W(DW), .DIV_W(DIVW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clk_out_mode(clk_out_mode),
        .div_sel(div_sel), .sclk_i(sclk_i), .wr_en(wr_en), .wr_data(wr_data),
        .ie_empty(ie_empty), .ie_end(ie_end), .flag_empty(flag_empty),
        .flag_end(flag_end), .irq_empty(irq_empty), .irq_end(irq_end),
        .sclk_o(sclk_o), .txd_o(txd_o)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    string sweep_tag = "";

    // Reference model state.
    bit          m_empty, m_end, m_sclk, m_txd, m_busy, m_drain;
    bit          m_s1, m_s2, m_prev;
    int          m_cnt;
    logic [7:0]  m_hold;
    bit          m_q[$];

    // Receiver view.
    bit rx_q[$];
    int falls = 0;
    bit prev_sclk = 1'b1;
    bit ext_run = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s%s at %0t: actual %0h expected %0h", tag, sweep_tag, $time, act, exp);
        end
    endtask

    task automatic model_load();
        for (int i = 0; i < DW; i++) m_q.push_back(m_hold[i]);
    endtask

    // Model step at each rising edge, using inputs and state before the edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_empty = 1; m_end = 1; m_sclk = 1; m_txd = 1; m_busy = 0; m_drain = 0;
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_cnt = 0; m_hold = '0; m_q.delete();
        end else begin
            bit f, r, act, old_empty;
            f = 0; r = 0;
            act = tx_en && m_busy;
            old_empty = m_empty;
            if (clk_out_mode) begin
                if (act && m_cnt == int'(div_sel)) begin f = m_sclk; r = !m_sclk; end
            end else if (act) begin
                f = m_prev && !m_s2; r = !m_prev && m_s2;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = sclk_i;
            if (act && clk_out_mode) begin
                if (m_cnt == int'(div_sel)) begin m_cnt = 0; m_sclk = !m_sclk; end
                else m_cnt++;
            end else begin
                m_cnt = 0; m_sclk = 1;
            end
            if (!tx_en) begin
                m_busy = 0; m_drain = 0; m_q.delete();
            end else if (!m_busy) begin
                if (!old_empty) begin model_load(); m_busy = 1; m_empty = 1; end
            end else if (!m_drain) begin
                if (f) begin
                    m_txd = m_q.pop_front();
                    if (m_q.size() == 0) begin
                        if (!old_empty) begin model_load(); m_empty = 1; end
                        else begin m_end = 1; m_drain = 1; end
                    end
                end
            end else if (r) begin
                m_busy = 0; m_drain = 0;
            end
            if (wr_en) begin m_hold = wr_data; m_empty = 0; m_end = 0; end
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Compare with the model and watch the line, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(flag_empty === m_empty, "R3", flag_empty, m_empty);
            chk(flag_end === m_end, "R7", flag_end, m_end);
            chk(sclk_o === (clk_out_mode ? m_sclk : 1'b1), "R4", sclk_o, m_sclk);
            chk(txd_o === m_txd, "R5", txd_o, m_txd);
            chk(irq_empty === (m_empty && ie_empty), "R3", irq_empty, m_empty && ie_empty);
            chk(irq_end === (m_end && ie_end), "R8", irq_end, m_end && ie_end);
            if (prev_sclk && !sclk_o) falls++;
            if (!prev_sclk && sclk_o) rx_q.push_back(txd_o);
            prev_sclk = sclk_o;
        end
    end

    task automatic host_wr(input logic [7:0] b);
        @(negedge clk); #1; wr_en = 1; wr_data = b;
        @(negedge clk); #1; wr_en = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!(flag_end && flag_empty));
        repeat (2 * (int'(div_sel) + 1) + 6) @(negedge clk);
    endtask

    function automatic int rx_val(input int n);
        int v = 0;
        for (int i = 0; i < n && i < rx_q.size(); i++) v |= int'(rx_q[i]) << i;
        return v;
    endfunction

    task automatic ext_clock();
        forever begin
            repeat (6) @(negedge clk);
            if (ext_run) sclk_i = !sclk_i; else sclk_i = 1'b1;
        end
    endtask

    initial begin
        fork ext_clock(); join_none
        repeat (5) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(flag_empty === 1'b1, "R1", flag_empty, 1);
        chk(flag_end === 1'b1, "R1", flag_end, 1);
        chk(sclk_o === 1'b1, "R1", sclk_o, 1);
        chk(txd_o === 1'b1, "R1", txd_o, 1);
        #1; ie_empty = 1; ie_end = 1;
        @(negedge clk);
        chk(irq_empty === 1'b1, "R3", irq_empty, 1);
        chk(irq_end === 1'b1, "R8", irq_end, 1);

        // R4 R5 R7: single byte, internal clock
        #1; div_sel = 1; tx_en = 1; rx_q.delete(); falls = 0;
        host_wr(8'hA5);
        wait_done();
        chk(rx_val(8) == 8'hA5 && rx_q.size() == 8, "R5", rx_val(8), 8'hA5);
        chk(falls == 8, "R4", falls, 8);
        chk(txd_o === 1'b1, "R7", txd_o, 1);

        // R6: back-to-back frames
        #1; div_sel = 2; rx_q.delete(); falls = 0;
        host_wr(8'h3C);
        do @(negedge clk); while (!flag_empty);
        host_wr(8'hC3);
        chk(flag_end === 1'b0, "R2", flag_end, 0);
        wait_done();
        chk(rx_val(16) == 16'hC33C && rx_q.size() == 16, "R6", rx_val(16), 16'hC33C);
        chk(falls == 16, "R6", falls, 16);

        // R7: idle level follows a zero last bit
        host_wr(8'h12);
        wait_done();
        chk(txd_o === 1'b0, "R7", txd_o, 0);

        // R10: disabled block stays idle, writes still land
        #1; tx_en = 0; div_sel = 3; falls = 0;
        host_wr(8'hFF);
        repeat (20) @(negedge clk);
        chk(falls == 0, "R10", falls, 0);
        chk(flag_empty === 1'b0, "R10", flag_empty, 0);
        #1; tx_en = 1;
        repeat (12) @(negedge clk);
        #1; tx_en = 0; falls = 0;
        repeat (12) @(negedge clk);
        chk(falls == 0 && sclk_o === 1'b1, "R10", falls, 0);
        #1; tx_en = 1;
        repeat (4) @(negedge clk);

        // R11: second write swept across the first frame
        #1; div_sel = 0; sweep_tag = " (R11 sweep)";
        for (int k = 0; k < 24; k++) begin
            rx_q.delete();
            host_wr(8'(k * 7 + 1));
            do @(negedge clk); while (!flag_empty);
            repeat (k) @(negedge clk);
            host_wr(8'(8'hF0 ^ k));
            wait_done();
            chk(rx_val(16) == ((int'(8'hF0 ^ k) << 8) | (k * 7 + 1)) && rx_q.size() == 16,
                "R11", rx_val(16), (int'(8'hF0 ^ k) << 8) | (k * 7 + 1));
        end
        sweep_tag = "";

        // R9: external clock
        #1; clk_out_mode = 0; falls = 0; ext_run = 1;
        host_wr(8'hDA);
        wait_done();
        repeat (30) @(negedge clk);
        chk(falls == 0, "R9", falls, 0);
        chk(txd_o === 1'b1, "R9", txd_o, 1);
        chk(flag_end === 1'b1, "R9", flag_end, 1);
        ext_run = 0;
        repeat (20) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule